// File: doc/BRIEF.md
# DMA external request handshake front end

This block sits between external I/O devices and a DMA transfer engine. It has four channels, each with a raw request pin from a device and an acknowledge pin back to it. Each channel carries its own configuration: an enable, the active level of the request pin, whether requests are taken by level or by edge, and the active level of the acknowledge pin. Request pins are brought to one active-high sense, passed through a synchroniser, and turned into pending requests. A fixed-priority arbiter then hands one channel at a time to the engine through a start pulse and a done input.

A granted channel sees its acknowledge go active at once. The transfer start is issued only after a qualification window. In that window a level-mode request must still be active as it stood one clock after the acknowledge rose; if it is not, the grant is withdrawn without a transfer. The acknowledge stays active until the engine signals done.

For level-mode channels the end-of-access strobe (chip-enable release) marks the point from which a still-active request counts as a new request. If the device has released its request by then, no extra transfer follows. Edge-mode channels keep a sticky pending flag, so an edge that arrives during their own transfer gives exactly one more transfer.

Top module: `dma_hs_frontend`

## Requirements
- R1: While rst_ni is low and right after it, xfer_start_o is 0 and every ack_pin_o bit equals its cfg_ack_pol_i bit, which is the inactive level.
- R2: With cfg_req_pol_i[c]=0 the request pin of channel c is active high; with cfg_req_pol_i[c]=1 it is active low. An inactive pin level never starts a transfer.
- R3: With cfg_edge_i[c]=0 (level mode), a request still present on the pin one clock after the acknowledge goes active leads to a single-cycle xfer_start_o exactly 3 clocks after the acknowledge goes active, with the default two-stage synchroniser.
- R4: In level mode, a request dropped in the same cycle the acknowledge goes active produces no xfer_start_o. The acknowledge returns to inactive within a few clocks.
- R5: With cfg_edge_i[c]=1, each transition of the normalised request into its active level sets a pending flag that holds until the channel is granted. A request held active does not retrigger, and an edge during the channel's own transfer gives exactly one further transfer.
- R6: Acknowledge bit c is active at the level given by cfg_ack_pol_i[c] (0: high, 1: low) from the grant through the cycle in which xfer_done_i is high. It is inactive in the following cycle.
- R7: At most one acknowledge is active at a time. Among pending channels the lowest index wins, and xfer_ch_o is held until xfer_done_i.
- R8: In level mode, once a transfer has begun, the channel is not granted again until cs_end_i has pulsed or the request has been seen inactive. A request still active when cs_end_i pulses is granted again; a request released before cs_end_i is not.
- R9: With cfg_en_i[c]=0 the request pin of channel c is ignored, its acknowledge is held inactive, and an edge seen while disabled leaves nothing pending after re-enable.
- R10: xfer_ch_o gives the granted channel's index in binary; it is valid while xfer_start_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | NUM_CH | Per-channel enable |
| cfg_req_pol_i | input | NUM_CH | Request active level, 1 = active low |
| cfg_edge_i | input | NUM_CH | Detection mode, 1 = edge, 0 = level |
| cfg_ack_pol_i | input | NUM_CH | Acknowledge active level, 1 = active low |
| req_pin_i | input | NUM_CH | Raw request pins from devices |
| ack_pin_o | output | NUM_CH | Acknowledge pins to devices |
| xfer_start_o | output | 1 | One-cycle start pulse to the engine |
| xfer_ch_o | output | $clog2(NUM_CH) | Granted channel index |
| xfer_done_i | input | 1 | Engine done pulse, ends the grant |
| cs_end_i | input | 1 | End-of-access strobe for the granted channel |

## Verification
The bench releases a level request in the very cycle its acknowledge rises, and again one cycle later. A design that samples the request at the wrong point would start a transfer it should abort, or abort one it should start. It signals done while a level request is still held and before the end-of-access strobe; a design without the re-arm rule would issue a spurious second transfer there, or would never re-arm after the strobe. Edge channels get a new edge during their own transfer and a long held level afterwards, which exposes a flag that is lost or that retriggers. Simultaneous requests, inverted polarities and a disabled channel that sees an edge cover priority inversion, wrong pin sense and state that survives a disable.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_XFER = 2'd2
  } hs_state_e;
endpackage

// File: rtl/dma_hs_sync.sv
module dma_hs_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dma_hs_detect.sv
module dma_hs_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,     // synchronised, polarity-normalised request
  input  logic en_i,
  input  logic edge_i,
  input  logic grant_i,   // this channel granted this cycle
  input  logic own_i,     // this channel currently holds the grant
  input  logic cs_end_i,  // end of access for this channel
  output logic pend_o
);
  logic act_q, edge_pend_q, mask_q;
  logic rise;

  assign rise = act_i & ~act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q       <= 1'b0;
      edge_pend_q <= 1'b0;
      mask_q      <= 1'b0;
    end else begin
      act_q <= act_i;
      // sticky edge flag; a new edge beats the clear on grant
      if (!en_i || !edge_i)  edge_pend_q <= 1'b0;
      else if (rise)         edge_pend_q <= 1'b1;
      else if (grant_i)      edge_pend_q <= 1'b0;
      // level re-arm mask: set on grant, cleared at end of access or release
      if (!en_i || edge_i)                        mask_q <= 1'b0;
      else if (grant_i)                           mask_q <= 1'b1;
      else if (cs_end_i || (!act_i && !own_i))    mask_q <= 1'b0;
    end
  end

  assign pend_o = en_i & (edge_i ? edge_pend_q : (act_i & ~mask_q));
endmodule

// File: rtl/dma_hs_arb.sv
module dma_hs_arb #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl
  import dma_hs_pkg::*;
#(
  parameter int N       = 4,
  parameter int ACK_LEN = 3,
  localparam int IW     = $clog2(N),
  localparam int CW     = $clog2(ACK_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          any_i,
  input  logic [IW-1:0] idx_i,
  input  logic [N-1:0]  act_i,
  input  logic [N-1:0]  edge_i,
  input  logic          done_i,
  output logic          grant_o,
  output logic          busy_o,
  output logic          xfer_o,
  output logic          start_o,
  output logic [IW-1:0] gch_o
);
  hs_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          start_q;
  logic [IW-1:0] gch_q;
  logic          qual_ok;

  assign grant_o = (state_q == ST_IDLE) && any_i;
  assign qual_ok = edge_i[gch_q] | act_i[gch_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      start_q <= 1'b0;
      gch_q   <= '0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (any_i) begin
          state_q <= ST_ACK;
          gch_q   <= idx_i;
          cnt_q   <= '0;
        end
        ST_ACK: begin
          if (cnt_q == CW'(ACK_LEN - 1)) begin
            // request seen through the synchroniser one cycle after ack rose
            if (qual_ok) begin
              state_q <= ST_XFER;
              start_q <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_XFER: if (done_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign xfer_o  = (state_q == ST_XFER);
  assign start_o = start_q;
  assign gch_o   = gch_q;
endmodule

// File: rtl/dma_hs_frontend.sv
module dma_hs_frontend #(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = $clog2(NUM_CH),
  localparam int ACK_LEN    = SYNC_STAGES + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] cfg_en_i,
  input  logic [NUM_CH-1:0] cfg_req_pol_i,
  input  logic [NUM_CH-1:0] cfg_edge_i,
  input  logic [NUM_CH-1:0] cfg_ack_pol_i,
  input  logic [NUM_CH-1:0] req_pin_i,
  output logic [NUM_CH-1:0] ack_pin_o,
  output logic              xfer_start_o,
  output logic [CH_W-1:0]   xfer_ch_o,
  input  logic              xfer_done_i,
  input  logic              cs_end_i
);
  logic [NUM_CH-1:0] req_norm, req_act, pend;
  logic              any_pend, grant, busy, xfer_busy;
  logic [CH_W-1:0]   sel_idx, gch;

  // normalise before syncing so reset state of the flops is always inactive
  assign req_norm = req_pin_i ^ cfg_req_pol_i;

  dma_hs_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_norm),
    .q_o   (req_act)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic is_gch;
    assign is_gch = (gch == CH_W'(c));

    dma_hs_detect u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .act_i   (req_act[c]),
      .en_i    (cfg_en_i[c]),
      .edge_i  (cfg_edge_i[c]),
      .grant_i (grant && (sel_idx == CH_W'(c))),
      .own_i   (busy && is_gch),
      .cs_end_i(cs_end_i && is_gch),
      .pend_o  (pend[c])
    );

    assign ack_pin_o[c] = (busy && is_gch && cfg_en_i[c]) ^ cfg_ack_pol_i[c];
  end

  dma_hs_arb #(.N(NUM_CH)) u_arb (
    .req_i(pend),
    .any_o(any_pend),
    .idx_o(sel_idx)
  );

  dma_hs_ctrl #(.N(NUM_CH), .ACK_LEN(ACK_LEN)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .any_i  (any_pend),
    .idx_i  (sel_idx),
    .act_i  (req_act & cfg_en_i),
    .edge_i (cfg_edge_i),
    .done_i (xfer_done_i),
    .grant_o(grant),
    .busy_o (busy),
    .xfer_o (xfer_busy),
    .start_o(xfer_start_o),
    .gch_o  (gch)
  );

  assign xfer_ch_o = gch;
endmodule

// File: rtl/dma_hs_frontend_chk.sv
module dma_hs_frontend_chk #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] ack_pin_o,
  input logic [NUM_CH-1:0] cfg_ack_pol_i,
  input logic [NUM_CH-1:0] cfg_en_i,
  input logic              xfer_start_o,
  input logic [CH_W-1:0]   xfer_ch_o,
  input logic              xfer_done_i,
  input logic              xfer_busy
);
  logic [NUM_CH-1:0] ack_act;
  assign ack_act = ack_pin_o ^ cfg_ack_pol_i;

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_idle_chk: assert (ack_act == '0 && !xfer_start_o);
    end
  end

  // R7
  ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_act));

  // R3
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |=> !xfer_start_o);

  // R3
  start_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_start_o && cfg_en_i[xfer_ch_o]) |-> ack_act[xfer_ch_o]);

  // R7
  grant_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_busy && !xfer_done_i) |=> (xfer_busy && $stable(xfer_ch_o)));

  // R6
  ack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_busy && xfer_done_i) |=> (ack_act == '0));
endmodule

bind dma_hs_frontend dma_hs_frontend_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ack_pin_o    (ack_pin_o),
  .cfg_ack_pol_i(cfg_ack_pol_i),
  .cfg_en_i     (cfg_en_i),
  .xfer_start_o (xfer_start_o),
  .xfer_ch_o    (xfer_ch_o),
  .xfer_done_i  (xfer_done_i),
  .xfer_busy    (xfer_busy)
);

// File: tb/sim_dma_hs_frontend.sv
module sim_dma_hs_frontend;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] en, rpol, edg, apol, pin;
  logic [3:0] ack;
  logic       start, done, cs_end;
  logic [1:0] ch;

  int checks = 0;
  int errors = 0;
  int start_cnt = 0;
  int exp_q[$];

  always #2 clk = ~clk;

  dma_hs_frontend u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(en), .cfg_req_pol_i(rpol),
    .cfg_edge_i(edg), .cfg_ack_pol_i(apol), .req_pin_i(pin),
    .ack_pin_o(ack), .xfer_start_o(start), .xfer_ch_o(ch),
    .xfer_done_i(done), .cs_end_i(cs_end)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic bit ackact(input int c);
    return ack[c] ^ apol[c];
  endfunction

  // monitor: scoreboard of expected start channels
  always @(negedge clk) begin
    if (rst_n && start) begin
      start_cnt++;
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL unexpected start R10 actual ch %0d expected none", ch);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(ch == 2'(e), "R10 start channel", ch, e);
      end
    end
  end

  task automatic wait_ack(input int c, input string rq);
    int n = 0;
    while (!ackact(c) && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(ackact(c), rq, ackact(c), 1);
  endtask

  task automatic wait_start(input string rq, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!start && n < 20);
    chk(start, rq, start, 1);
  endtask

  task automatic finish_xfer(input int c, input bit with_cs);
    if (with_cs) begin
      cs_end = 1'b1;
      @(negedge clk);
      cs_end = 1'b0;
    end
    done = 1'b1;
    chk(ackact(c), "R6 ack active in done cycle", ackact(c), 1);
    @(negedge clk);
    done = 1'b0;
    chk(!ackact(c), "R6 ack released after done", ackact(c), 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R7 actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, s0;
    en = 4'b1111; rpol = 4'b1000; edg = 4'b0010; apol = 4'b1001;
    pin = 4'b1000; done = 1'b0; cs_end = 1'b0;
    idle(3);
    // R1 reset state
    chk(ack == apol, "R1 ack inactive in reset", ack, apol);
    chk(!start, "R1 no start in reset", start, 0);
    rst_n = 1'b1;
    idle(6);
    chk(ack == apol, "R1 ack inactive after reset", ack, apol);
    chk(start_cnt == 0, "R2 inactive pins start nothing", start_cnt, 0);

    // R3: level request, exact start latency, active-low ack on ch0
    exp_q.push_back(0);
    pin[0] = 1'b1;
    wait_ack(0, "R3 ack rises");
    chk(ack[0] == 1'b0, "R6 active-low ack level", ack[0], 0);
    wait_start("R3 start issued", n);
    chk(n == 3, "R3 start latency after ack", n, 3);
    chk(ch == 2'd0, "R10 channel index", ch, 0);
    pin[0] = 1'b0;
    idle(4);
    chk(ackact(0), "R6 ack held during transfer", ackact(0), 1);
    finish_xfer(0, 1'b1);
    idle(8);

    // R4: request released as ack rises -> no transfer
    s0 = start_cnt;
    pin[0] = 1'b1;
    wait_ack(0, "R4 ack rises");
    pin[0] = 1'b0;
    idle(8);
    chk(start_cnt == s0, "R4 no start after early release", start_cnt - s0, 0);
    chk(!ackact(0), "R4 ack withdrawn", ackact(0), 0);

    // R3 boundary: released one cycle after ack -> transfer
    exp_q.push_back(0);
    pin[0] = 1'b1;
    wait_ack(0, "R3 boundary ack");
    @(negedge clk);
    pin[0] = 1'b0;
    wait_start("R3 boundary start", n);
    finish_xfer(0, 1'b1);
    idle(8);

    // R8: done before end of access with request held
    exp_q.push_back(0);
    pin[0] = 1'b1;
    wait_ack(0, "R8 first ack");
    wait_start("R8 first start", n);
    finish_xfer(0, 1'b0);
    s0 = start_cnt;
    idle(10);
    chk(!ackact(0), "R8 no regrant before cs_end", ackact(0), 0);
    chk(start_cnt == s0, "R8 no start before cs_end", start_cnt - s0, 0);
    exp_q.push_back(0);
    cs_end = 1'b1;
    @(negedge clk);
    cs_end = 1'b0;
    wait_ack(0, "R8 regrant after cs_end");
    wait_start("R8 second start", n);
    pin[0] = 1'b0;
    idle(2);
    finish_xfer(0, 1'b1);
    s0 = start_cnt;
    idle(10);
    chk(start_cnt == s0, "R8 released before cs_end no regrant", start_cnt - s0, 0);

    // R5: edge mode on ch1
    s0 = start_cnt;
    exp_q.push_back(1);
    pin[1] = 1'b1;
    wait_ack(1, "R5 edge ack");
    wait_start("R5 edge start", n);
    pin[1] = 1'b0;
    idle(3);
    pin[1] = 1'b1;
    exp_q.push_back(1);
    idle(4);
    finish_xfer(1, 1'b1);
    wait_start("R5 held edge start", n);
    idle(2);
    finish_xfer(1, 1'b1);
    idle(15);
    chk(start_cnt - s0 == 2, "R5 exactly two edge transfers", start_cnt - s0, 2);
    pin[1] = 1'b0;
    idle(4);

    // R7: ch0 and ch2 together, lowest index wins
    exp_q.push_back(0);
    exp_q.push_back(2);
    pin[0] = 1'b1;
    pin[2] = 1'b1;
    wait_ack(0, "R7 ch0 first");
    chk(!ackact(2), "R7 ch2 waits", ackact(2), 0);
    wait_start("R7 ch0 start", n);
    pin[0] = 1'b0;
    idle(5);
    chk(ch == 2'd0 && !ackact(2), "R7 grant held", ch, 0);
    finish_xfer(0, 1'b1);
    wait_ack(2, "R7 ch2 second");
    wait_start("R7 ch2 start", n);
    pin[2] = 1'b0;
    finish_xfer(2, 1'b1);
    idle(6);

    // R2: ch3 active-low request with active-low ack
    exp_q.push_back(3);
    pin[3] = 1'b0;
    wait_ack(3, "R2 active-low request");
    chk(ack[3] == 1'b0, "R2 ch3 ack driven low", ack[3], 0);
    wait_start("R2 start", n);
    pin[3] = 1'b1;
    finish_xfer(3, 1'b1);
    chk(ack[3] == 1'b1, "R2 ch3 ack idle high", ack[3], 1);
    idle(6);

    // R9: disabled channels ignore requests
    s0 = start_cnt;
    en[2] = 1'b0;
    pin[2] = 1'b1;
    idle(15);
    chk(start_cnt == s0, "R9 disabled level ignored", start_cnt - s0, 0);
    chk(ack[2] == apol[2], "R9 ack inactive when disabled", ack[2], apol[2]);
    pin[2] = 1'b0;
    en[2] = 1'b1;
    en[1] = 1'b0;
    pin[1] = 1'b1;
    idle(10);
    en[1] = 1'b1;
    idle(12);
    chk(start_cnt == s0, "R9 edge while disabled dropped", start_cnt - s0, 0);
    pin[1] = 1'b0;
    idle(4);

    chk(exp_q.size() == 0, "R5 all expected starts seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule